// File: doc/BRIEF.md
# Command-Queue I2C Bus Master

This block is an I2C bus master that software runs by queueing command words and reading back received bytes. Both queues sit behind a small 32-bit register port. A transmit command either sends one byte or asks for a number of bytes to be read. A send command may be preceded by a START condition. Any command may be followed by a STOP. The controller drives SCL and SDA as open-drain pull-downs and reads the resolved line levels back.

Each SCL bit period is built from 16 ticks. One tick lasts a programmable number of system clocks. A status word records three things: that a sequence ended in STOP, that the engine is busy, and that a target refused a written byte. The status flags are cleared by writing ones back. When a target refuses a byte, the controller ends the transfer with a STOP. It then throws away the rest of that queued transfer, so that the next transfer in the queue starts cleanly.

Top module: `cmd_i2c_master`

## Requirements
- R1: After reset, status (offset 0x14) and control (offset 0x1C) read 0, offset 0x28 reads the revision value 6, and a receive pop (offset 0x04) reads 0x100.
- R2: One SCL bit lasts 16 ticks of DIV system clocks, where DIV is control bits 7:0. SCL is pulled low for the first 8 ticks and released for the last 8. SDA driven by the master never changes while SCL is released inside a byte, and never changes within 2 ticks after SCL falls.
- R3: A transmit entry (a write to offset 0x00) carries a byte in bits 7:0. Bit 8 requests a START before the byte and bit 9 requests a STOP after it. Bytes go out MSB first, and the target's acknowledge is sampled in the ninth bit.
- R4: An entry with bit 10 set is a read. Its bits 7:0 give the byte count. Each received byte enters the receive queue. The master ACKs every byte except the last, which it NAKs.
- R5: A START entry that arrives while the bus is held without a STOP produces a repeated START, with no STOP in between.
- R6: A receive pop returns the byte in bits 7:0 and sets bit 8 when the queue is empty. A pop of an empty queue leaves the queue unchanged.
- R7: Status bit 27 is set when a STOP completes. Status bit 28 reads 1 while a transfer is in progress.
- R8: When a target NAKs a written byte, status bit 21 is set and a STOP is issued. Queued entries are then discarded up to and including the next STOP-flagged entry, and bit 27 is still set.
- R9: Writing 1 to a status bit clears it. Writing back a value just read clears every flag that was set.
- R10: The transmit queue holds 8 entries. A push to a full queue is dropped and sets the sticky status bit 0.
- R11: Writing control bit 9 empties the transmit queue, and writing control bit 10 empties the receive queue.
- R12: While control bit 11 (enable) is clear, both lines stay released and queued entries are not consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive queue at 0x04) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |

## Verification
A behavioural target on the wired-AND bus records every START, STOP and byte it sees, and acknowledges only its own address. A plain write separates byte order and flag handling from timing. A multi-byte read checks ACK placement, with the NAK coming only on the last byte. A write followed by a read with a repeated START separates a held bus from a released one. A transfer to an absent address shows the discard of its tail, and the following queued transfer must still reach the bus. A timing monitor runs on every clock and compares SCL high time and SDA change points with the tick rules. Filling the queue while the block is disabled shows, in one transfer, both the 8-entry limit and the dropped ninth push.

// File: rtl/cmd_i2c_master.sv
module cmd_i2c_master #(
  parameter int DEPTH    = 8,
  parameter int REVISION = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  input  logic        scl_in,
  input  logic        sda_in
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [7:0] A_TX = 8'h00, A_RX = 8'h04, A_ST = 8'h14, A_CTL = 8'h1C, A_REV = 8'h28;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_START, S_BYTE, S_STOP} state_t;

  state_t      state;
  logic [3:0]  ph, bitn;
  logic [7:0]  dcnt, div, sh, left;
  logic        en, sda_q, rd_mode, stop_f, skip, got_nak;
  logic        st_ovf, st_nak, st_done;

  logic [10:0] txm [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_n;
  logic [7:0]  rxm [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_n;

  wire ctl_wr   = bus_wr && bus_addr == A_CTL;
  wire tx_wr    = bus_wr && bus_addr == A_TX;
  wire st_wr    = bus_wr && bus_addr == A_ST;
  wire tx_flush = ctl_wr && bus_wdata[9];
  wire rx_flush = ctl_wr && bus_wdata[10];
  wire tx_push  = tx_wr && tx_n != FULL;
  wire rx_pop   = bus_rd && bus_addr == A_RX && rx_n != '0;

  wire [10:0] head  = txm[tx_rp];
  wire fetch_ok     = en && tx_n != '0 && (state == S_IDLE || state == S_HOLD);
  wire tx_pop       = fetch_ok;
  wire active       = state == S_START || state == S_BYTE || state == S_STOP;
  wire stretch      = ph[3] && !scl_in;
  wire [7:0] dmax   = (div == 8'd0) ? 8'd0 : div - 8'd1;
  wire tick         = active && !stretch && dcnt == dmax;
  wire slot_end     = tick && ph == 4'd15;
  wire byte_end     = slot_end && state == S_BYTE && bitn == 4'd8;
  wire rx_push      = byte_end && rd_mode && rx_n != FULL;
  wire nak_set      = byte_end && !rd_mode && got_nak;
  wire done_set     = slot_end && state == S_STOP;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:28], bus_wdata[26:22], bus_wdata[20:12]};

  assign scl_drive_low = state == S_HOLD || (active && !ph[3]);
  assign sda_drive_low = sda_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_RX:  bus_rdata = {23'd0, rx_n == '0, rx_n == '0 ? 8'h00 : rxm[rx_rp]};
      A_ST:  begin
        bus_rdata[0]  = st_ovf;
        bus_rdata[21] = st_nak;
        bus_rdata[27] = st_done;
        bus_rdata[28] = state != S_IDLE;
      end
      A_CTL: bus_rdata = {20'd0, en, 3'd0, div};
      A_REV: bus_rdata = 32'(REVISION);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_n <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_n <= '0;
    end else begin
      if (tx_push) begin
        txm[tx_wp] <= bus_wdata[10:0];
        tx_wp <= tx_wp + 1'b1;
      end
      if (tx_pop) tx_rp <= tx_rp + 1'b1;
      tx_n <= tx_n + CW'(tx_push) - CW'(tx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_n <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_n <= '0;
    end else begin
      if (rx_push) begin
        rxm[rx_wp] <= sh;
        rx_wp <= rx_wp + 1'b1;
      end
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      rx_n <= rx_n + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0; div <= '0;
      st_ovf <= 1'b0; st_nak <= 1'b0; st_done <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en  <= bus_wdata[11];
        div <= bus_wdata[7:0];
      end
      st_ovf  <= (tx_wr && tx_n == FULL) || (st_ovf  && !(st_wr && bus_wdata[0]));
      st_nak  <= nak_set  || (st_nak  && !(st_wr && bus_wdata[21]));
      st_done <= done_set || (st_done && !(st_wr && bus_wdata[27]));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; ph <= '0; dcnt <= '0; bitn <= '0; sh <= '0; left <= '0;
      sda_q <= 1'b0; rd_mode <= 1'b0; stop_f <= 1'b0; skip <= 1'b0; got_nak <= 1'b0;
    end else begin
      if (!en) begin
        state <= S_IDLE; sda_q <= 1'b0; ph <= '0; dcnt <= '0;
      end else if (fetch_ok) begin
        if (skip) begin
          if (head[9]) skip <= 1'b0;
        end else begin
          stop_f <= head[9]; rd_mode <= head[10];
          ph <= '0; dcnt <= '0; bitn <= '0;
          if (head[10]) begin
            left <= head[7:0];
            if (head[7:0] != 8'd0) state <= S_BYTE;
            else if (head[9]) state <= S_STOP;
          end else begin
            sh <= head[7:0];
            state <= head[8] ? S_START : S_BYTE;
          end
        end
      end else if (active) begin
        dcnt <= tick ? 8'd0 : (stretch ? dcnt : dcnt + 8'd1);
        if (tick) begin
          ph <= ph + 4'd1;
          case (state)
            S_START: begin
              if (ph == 4'd1) sda_q <= 1'b0;
              if (ph == 4'd11) sda_q <= 1'b1;
              if (ph == 4'd15) begin state <= S_BYTE; bitn <= '0; end
            end
            S_STOP: begin
              if (ph == 4'd1) sda_q <= 1'b1;
              if (ph == 4'd11) sda_q <= 1'b0;
              if (ph == 4'd15) state <= S_IDLE;
            end
            default: begin
              if (ph == 4'd1)
                sda_q <= rd_mode ? (bitn == 4'd8 && left != 8'd1) : (bitn != 4'd8 && !sh[7]);
              if (ph == 4'd11) begin
                if (rd_mode && bitn != 4'd8) sh <= {sh[6:0], sda_in};
                if (!rd_mode && bitn == 4'd8) got_nak <= sda_in;
              end
              if (ph == 4'd15) begin
                if (bitn != 4'd8) begin
                  bitn <= bitn + 4'd1;
                  if (!rd_mode) sh <= {sh[6:0], 1'b0};
                end else begin
                  bitn <= '0;
                  if (rd_mode) begin
                    left <= left - 8'd1;
                    if (left == 8'd1) state <= stop_f ? S_STOP : S_HOLD;
                  end else if (got_nak) begin
                    state <= S_STOP;
                    skip  <= !stop_f;
                  end else begin
                    state <= stop_f ? S_STOP : S_HOLD;
                  end
                end
              end
            end
          endcase
        end
      end
      if (tx_flush) skip <= 1'b0;
    end

  assert_sda_steady_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BYTE && $past(state) == S_BYTE && ph[3] && $past(ph[3])) |-> $stable(sda_q));

  assert_done_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(state) == S_STOP);

  assert_rx_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RX && rx_n == '0 && !rx_push && !rx_flush) |=> ($stable(rx_rp) && rx_n == '0));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_n == FULL && !tx_pop) |=> (tx_n == FULL && st_ovf));

  assert_disabled_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_drive_low && !sda_drive_low));
endmodule

// File: tb/cmd_i2c_master_tb.sv
module cmd_i2c_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam logic [7:0] A_TX = 8'h00, A_RX = 8'h04, A_ST = 8'h14, A_CTL = 8'h1C, A_REV = 8'h28;
  localparam logic [31:0] F_START = 32'h100, F_STOP = 32'h200, F_READ = 32'h400;
  localparam logic [31:0] EN = 32'h800;
  localparam logic [6:0] SLV = 7'h50;

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic scl_dl, sda_dl, slave_low = 1'b0;
  wire scl_in = !scl_dl;
  wire sda_in = !(sda_dl || slave_low);

  int checks = 0, fails = 0;

  cmd_i2c_master u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_drive_low(scl_dl),
    .sda_drive_low(sda_dl), .scl_in(scl_in), .sda_in(sda_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural target model
  bq_t seen, tx_src;
  bit  m_acks[$];
  int  n_start = 0, n_stop = 0, cnt = 100;
  bit  ps = 1, pd = 1, is_addr = 0, rd_dir = 0, sending = 0, acked = 0, m_ack = 0;
  logic [7:0] rsh = '0, txb = '0;

  // timing monitor
  int since_fall = 0, hi_cnt = 0, last_hi = 0, timing_err = 0;
  bit p_scl = 0, p_sda = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ps && scl_in && pd && !sda_in) begin
        n_start++; cnt = -1; is_addr = 1; sending = 0; slave_low = 0;
      end else if (ps && scl_in && !pd && sda_in) begin
        n_stop++; sending = 0; cnt = 100;
      end else if (!ps && scl_in) begin
        if (cnt >= 0 && cnt < 8 && !sending) rsh = {rsh[6:0], sda_in};
        if (cnt == 8 && sending) begin m_ack = !sda_in; m_acks.push_back(m_ack); end
      end else if (ps && !scl_in && cnt < 50) begin
        cnt++;
        if (cnt == 8) begin
          if (!sending) begin
            seen.push_back(rsh);
            if (is_addr) begin acked = (rsh[7:1] == SLV); rd_dir = rsh[0]; end
            else acked = 1;
            slave_low = acked;
          end else slave_low = 0;
        end else if (cnt == 9) begin
          cnt = 0; slave_low = 0;
          if (is_addr) begin is_addr = 0; sending = rd_dir && acked; end
          else if (sending && !m_ack) sending = 0;
          if (sending) begin
            txb = (tx_src.size() != 0) ? tx_src.pop_front() : 8'hFF;
            slave_low = !txb[7];
          end
        end else if (sending && cnt >= 1 && cnt <= 7) slave_low = !txb[7-cnt];
      end
      ps = scl_in; pd = sda_in;
      if (scl_dl && !p_scl) since_fall = 0; else since_fall++;
      if (sda_dl != p_sda && scl_dl && since_fall < 2*DIV) timing_err++;
      if (!scl_dl) hi_cnt++;
      else if (!p_scl) begin last_hi = hi_cnt; hi_cnt = 0; end
      p_scl = scl_dl; p_sda = sda_dl;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_seen(input string tag, input bq_t exp);
    checks++;
    if (seen.size() != exp.size()) begin
      fails++;
      $display("FAIL %s actual=%0d bytes expected=%0d bytes", tag, seen.size(), exp.size());
    end else
      foreach (exp[i]) if (seen[i] !== exp[i]) begin
        fails++;
        $display("FAIL %s actual=%0h expected=%0h", tag, seen[i], exp[i]);
        break;
      end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1; d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(A_ST, v);
      if (v[27]) break;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_ST, v);  chk("R1 status", v, 32'h0);
    rd(A_CTL, v); chk("R1 control", v, 32'h0);
    rd(A_REV, v); chk("R1 revision", v, 32'd6);
    rd(A_RX, v);  chk("R1 rx empty", v, 32'h100);

    // R3 plain write, R7 busy/done, R2 timing, R9 clear
    wr(A_CTL, EN | DIV);
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, 32'h12);
    wr(A_TX, F_STOP | 32'h34);
    rd(A_ST, v); chk("R7 busy", {31'd0, v[28]}, 32'd1);
    wait_done();
    chk_seen("R3 bytes", '{8'hA0, 8'h12, 8'h34});
    chk("R3 starts", n_start, 1);
    chk("R3 stops", n_stop, 1);
    rd(A_ST, v); chk("R7 done only", v, 32'h0800_0000);
    chk("R2 scl high clocks", last_hi, 8*DIV);
    wr(A_ST, v);
    rd(A_ST, v); chk("R9 w1c", v, 32'h0);

    // R4 two-byte read with ACK then NAK
    seen.delete(); m_acks.delete();
    tx_src.push_back(8'h5A); tx_src.push_back(8'hC3);
    wr(A_TX, F_START | 32'hA1);
    wr(A_TX, F_READ | F_STOP | 32'd2);
    wait_done();
    rd(A_RX, v); chk("R4 rx byte0", v, 32'h5A);
    rd(A_RX, v); chk("R4 rx byte1", v, 32'hC3);
    chk("R4 ack count", m_acks.size(), 2);
    if (m_acks.size() == 2) begin
      chk("R4 ack first", m_acks[0], 1);
      chk("R4 nak last", m_acks[1], 0);
    end
    rd(A_RX, v); chk("R6 empty flag", v, 32'h100);
    rd(A_RX, v); chk("R6 empty again", v, 32'h100);
    wr(A_ST, 32'hFFFF_FFFF);
    tx_src.push_back(8'h77);
    wr(A_TX, F_START | 32'hA1);
    wr(A_TX, F_READ | F_STOP | 32'd1);
    wait_done();
    rd(A_RX, v); chk("R6 pop after empty pops", v, 32'h77);
    rd(A_RX, v); chk("R6 empty after", v, 32'h100);
    wr(A_ST, 32'hFFFF_FFFF);

    // R5 repeated start
    seen.delete(); s0 = n_stop; n_start = 0;
    tx_src.push_back(8'h3C);
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, 32'h07);
    wr(A_TX, F_START | 32'hA1);
    wr(A_TX, F_READ | F_STOP | 32'd1);
    wait_done();
    chk("R5 starts", n_start, 2);
    chk("R5 stops", n_stop - s0, 1);
    chk_seen("R5 bytes", '{8'hA0, 8'h07, 8'hA1});
    rd(A_RX, v); chk("R5 rx", v, 32'h3C);
    wr(A_ST, 32'hFFFF_FFFF);

    // R8 nak discard
    seen.delete(); s0 = n_stop;
    wr(A_TX, F_START | 32'h66);
    wr(A_TX, 32'h11);
    wr(A_TX, F_STOP | 32'h22);
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, F_STOP | 32'h99);
    repeat (3000) @(negedge clk);
    chk_seen("R8 bytes", '{8'h66, 8'hA0, 8'h99});
    chk("R8 stops", n_stop - s0, 2);
    rd(A_ST, v); chk("R8 status", v, 32'h0820_0000);
    wr(A_ST, v);

    // R10 overflow while disabled, R12 disabled
    seen.delete(); n_start = 0;
    wr(A_CTL, DIV);
    wr(A_TX, F_START | 32'hA0);
    for (int i = 1; i <= 6; i++) wr(A_TX, 32'(i));
    wr(A_TX, F_STOP | 32'h55);
    wr(A_TX, F_STOP | 32'hEE);
    repeat (200) @(negedge clk);
    chk("R12 lines released", {30'd0, scl_dl, sda_dl}, 32'h0);
    chk("R12 no start while disabled", n_start, 0);
    rd(A_ST, v); chk("R10 overflow flag", v, 32'h1);
    wr(A_CTL, EN | DIV);
    wait_done();
    chk_seen("R10 eight entries kept", '{8'hA0, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h55});
    rd(A_ST, v); chk("R10 sticky", v, 32'h0800_0001);
    wr(A_ST, v);

    // R11 flushes
    seen.delete(); n_start = 0;
    wr(A_CTL, DIV);
    wr(A_TX, F_START | 32'hA0);
    wr(A_TX, F_STOP | 32'h01);
    wr(A_CTL, DIV | 32'h200);
    wr(A_CTL, EN | DIV);
    repeat (500) @(negedge clk);
    chk("R11 tx flush", n_start, 0);
    rd(A_ST, v); chk("R11 idle after flush", v, 32'h0);
    tx_src.push_back(8'h11); tx_src.push_back(8'h22);
    wr(A_TX, F_START | 32'hA1);
    wr(A_TX, F_READ | F_STOP | 32'd2);
    wait_done();
    wr(A_CTL, EN | DIV | 32'h400);
    rd(A_RX, v); chk("R11 rx flush", v, 32'h100);

    chk("R2 sda change timing", timing_err, 0);
    summary();
    $finish;
  end
endmodule